// File: doc/BRIEF.md
# PLL and Bus Clock Frequency Calculator

This block works out, in hertz, the output frequency of the main PLL and the peripheral bus clock derived from it. It reads three words: the PLL parameter word, the hardware strap word and the clock-select word. A one-bit format input chooses between two generations of PLL field layout. In the older layout, an extra "programmed" flag decides whether the PLL fields are used at all. When they are not used, a strap-selected frequency table supplies the result instead.

A start pulse captures all inputs. Every quotient (the PLL ratios and the bus divide) is then produced in turn by one shared restoring divider, so the block has no combinational divide. The controller is a state machine with these states: IDLE, DECODE, RATIO_A, RATIO_B, SCALE, BUSDIV and FINISH.

- IDLE to DECODE on an accepted start.
- DECODE to SCALE when the PLL is off, bypassed or table-driven; otherwise DECODE to RATIO_A.
- RATIO_A to RATIO_B (newer layout) or to SCALE (older layout) when its division completes.
- RATIO_B to SCALE when its division completes.
- SCALE to BUSDIV.
- BUSDIV to FINISH when the bus division completes.
- FINISH to IDLE.

Top module: `pllfreq_calc`

## Requirements
- R1: The reference clock is 25 000 000 Hz when strap bit 23 is 1. Otherwise it is 48 000 000 Hz when strap bit 18 is 1, and 24 000 000 Hz in every other case.
- R2: When the off bit is 1, hpll_hz and apb_hz are both 0. The off bit is PLL bit 20 in the newer layout (fmt_new=1) and PLL bit 18 in the older layout (fmt_new=0). The off bit takes priority over every other field.
- R3: A set bypass bit makes the multiplier 1. The bypass bit is PLL bit 19 in the newer layout. In the older layout it is PLL bit 17, and it counts only when prog_flags bit 10 is 1.
- R4: In the newer layout, m is PLL bits 12:5, n is bits 4:0 and p is bits 18:13. The multiplier is ((m+1)/(n+1))/(p+1), with each division truncated. hpll_hz is the reference clock times the multiplier, kept to its low 32 bits.
- R5: In the older layout with prog_flags bit 10 set, n is PLL bits 10:5, od is bit 4 and d is bits 3:0. The multiplier is (2-od) times the truncated (n+2)/(d+1).
- R6: In the older layout with prog_flags bit 10 clear, strap bits 9:8 (values 0..3) select the frequency. With a 25 MHz reference, the choices are 400, 375, 350 and 425 MHz. With any other reference, they are 384, 360, 336 and 408 MHz.
- R7: apb_hz is hpll_hz divided by (clock-select bits 25:23 plus 1), truncated, and then divided by 4 in the newer layout or by 2 in the older one.
- R8: Inputs are captured on the accepted start. Input changes after that cycle do not affect the result.
- R9: done is high for exactly one cycle per computation. busy is high from the cycle after an accepted start through the done cycle. hpll_hz and apb_hz hold their values while the block is idle.
- R10: A start pulse while busy is high is ignored: the running computation finishes with its own inputs.
- R11: After reset, busy, done, hpll_hz and apb_hz are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation (accepted only when idle) |
| fmt_new | input | 1 | 1 = newer PLL layout, 0 = older layout |
| pll_word | input | 32 | PLL parameter word |
| strap_word | input | 32 | Hardware strap word |
| clksel_word | input | 32 | Clock-select word holding the bus divider field |
| prog_flags | input | 32 | Flag word; bit 10 marks the older-layout PLL as programmed |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| hpll_hz | output | 32 | PLL output frequency in Hz |
| apb_hz | output | 32 | Bus clock frequency in Hz |

## Verification
The assertions check the handshake on every cycle: done lasts one cycle, busy rises only after a start, a start during busy does not abort the run, and results stay still while idle. At every done they also check that an off PLL gives zeros and that the bus clock never exceeds half the PLL clock. The arithmetic itself can only be shown by the bench scenarios. These cover the reference clock priority, both layouts' ratio truncation, the strap table, the bypass and off priorities, 32-bit wrap of the product, and inputs changed or restarted mid-run.

// File: rtl/pllfreq_pkg.sv
package pllfreq_pkg;

    localparam int unsigned DW = 32;

    // reference clock strap positions
    localparam int unsigned STRAP_REF25_BIT = 23;
    localparam int unsigned STRAP_REF48_BIT = 18;
    localparam int unsigned STRAP_SEL_LO    = 8;

    // newer layout
    localparam int unsigned NEW_OFF_BIT = 20;
    localparam int unsigned NEW_BYP_BIT = 19;
    localparam int unsigned NEW_P_LO    = 13;
    localparam int unsigned NEW_M_LO    = 5;

    // older layout
    localparam int unsigned OLD_OFF_BIT = 18;
    localparam int unsigned OLD_BYP_BIT = 17;
    localparam int unsigned OLD_N_LO    = 5;
    localparam int unsigned OLD_OD_BIT  = 4;
    localparam int unsigned PROG_BIT    = 10;

    // clock-select divider field
    localparam int unsigned PDIV_LO = 23;

    localparam logic [DW-1:0] REF_24M = DW'(24_000_000);
    localparam logic [DW-1:0] REF_25M = DW'(25_000_000);
    localparam logic [DW-1:0] REF_48M = DW'(48_000_000);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_RATIO_A,
        ST_RATIO_B,
        ST_SCALE,
        ST_BUSDIV,
        ST_FINISH
    } calc_state_e;

    function automatic logic [DW-1:0] strap_table_hz(input logic ref25, input logic [1:0] sel);
        logic [DW-1:0] mhz;
        unique case ({ref25, sel})
            3'b000: mhz = DW'(384);
            3'b001: mhz = DW'(360);
            3'b010: mhz = DW'(336);
            3'b011: mhz = DW'(408);
            3'b100: mhz = DW'(400);
            3'b101: mhz = DW'(375);
            3'b110: mhz = DW'(350);
            default: mhz = DW'(425);
        endcase
        return mhz * DW'(1_000_000);
    endfunction

endpackage

// File: rtl/pllfreq_decode.sv
module pllfreq_decode
    import pllfreq_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         fmt_new,
    input  logic [W-1:0] pll_word,
    input  logic [W-1:0] strap_word,
    input  logic [W-1:0] clksel_word,
    input  logic         programmed,
    output logic [W-1:0] ref_hz,
    output logic [W-1:0] table_hz,
    output logic         is_off,
    output logic         is_bypass,
    output logic         use_table,
    output logic         two_stage,
    output logic         double_a,
    output logic [W-1:0] num_a,
    output logic [W-1:0] den_a,
    output logic [W-1:0] den_b,
    output logic [W-1:0] den_bus,
    output logic [1:0]   bus_shift
);

    logic       ref25;
    logic       ref48;
    logic [1:0] strap_sel;
    logic [7:0] nf_m;
    logic [4:0] nf_n;
    logic [5:0] nf_p;
    logic [5:0] of_n;
    logic [3:0] of_d;
    logic [2:0] pdiv;

    always_comb begin
        ref25     = strap_word[STRAP_REF25_BIT];
        ref48     = strap_word[STRAP_REF48_BIT];
        strap_sel = strap_word[STRAP_SEL_LO +: 2];
        nf_m      = pll_word[NEW_M_LO +: 8];
        nf_n      = pll_word[4:0];
        nf_p      = pll_word[NEW_P_LO +: 6];
        of_n      = pll_word[OLD_N_LO +: 6];
        of_d      = pll_word[3:0];
        pdiv      = clksel_word[PDIV_LO +: 3];
    end

    always_comb begin
        if (ref25)      ref_hz = REF_25M;
        else if (ref48) ref_hz = REF_48M;
        else            ref_hz = REF_24M;
    end

    assign table_hz = strap_table_hz(ref25, strap_sel);
    assign den_bus  = W'(pdiv) + W'(1);

    always_comb begin
        if (fmt_new) begin
            is_off    = pll_word[NEW_OFF_BIT];
            is_bypass = pll_word[NEW_BYP_BIT];
            use_table = 1'b0;
            two_stage = 1'b1;
            double_a  = 1'b0;
            num_a     = W'(nf_m) + W'(1);
            den_a     = W'(nf_n) + W'(1);
            den_b     = W'(nf_p) + W'(1);
            bus_shift = 2'd2;
        end else begin
            is_off    = pll_word[OLD_OFF_BIT];
            is_bypass = programmed & pll_word[OLD_BYP_BIT];
            use_table = ~programmed;
            two_stage = 1'b0;
            double_a  = ~pll_word[OLD_OD_BIT];
            num_a     = W'(of_n) + W'(2);
            den_a     = W'(of_d) + W'(1);
            den_b     = W'(1);
            bus_shift = 2'd1;
        end
    end

endmodule

// File: rtl/pllfreq_div.sv
module pllfreq_div #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         ready,
    output logic [W-1:0] quotient
);

    localparam int unsigned CW = $clog2(W) + 1;

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic [W:0]    rem_sh;
    logic [W:0]    rem_sub;
    logic          fits;

    always_comb begin
        rem_sh  = {rem_q[W-1:0], quo_q[W-1]};
        rem_sub = rem_sh - {1'b0, dvs_q};
        fits    = rem_sh >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            quo_q    <= '0;
            dvs_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            ready    <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (go) begin
                rem_q    <= '0;
                quo_q    <= dividend;
                dvs_q    <= divisor;
                cnt_q    <= '0;
                active_q <= 1'b1;
            end else if (active_q) begin
                rem_q <= fits ? rem_sub : rem_sh;
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q + CW'(1);
                if (cnt_q == CW'(W - 1)) begin
                    active_q <= 1'b0;
                    ready    <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

endmodule

// File: rtl/pllfreq_calc.sv
module pllfreq_calc
    import pllfreq_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         fmt_new,
    input  logic [W-1:0] pll_word,
    input  logic [W-1:0] strap_word,
    input  logic [W-1:0] clksel_word,
    input  logic [W-1:0] prog_flags,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hpll_hz,
    output logic [W-1:0] apb_hz
);

    calc_state_e state_q, state_n;

    logic         fmt_q;
    logic [W-1:0] pll_q;
    logic [W-1:0] strap_q;
    logic [W-1:0] clksel_q;
    logic         prog_q;

    logic [W-1:0] mult_q;
    logic [W-1:0] hpll_q;
    logic [W-1:0] apb_q;
    logic         div_go_q;

    logic [W-1:0] ref_hz, table_hz, num_a, den_a, den_b, den_bus;
    logic         is_off, is_bypass, use_table, two_stage, double_a;
    logic [1:0]   bus_shift;

    logic [W-1:0] div_num, div_den, div_quo;
    logic         div_ready;
    logic         accept;
    logic         is_div_state_n;

    pllfreq_decode #(.W(W)) u_decode (
        .fmt_new     (fmt_q),
        .pll_word    (pll_q),
        .strap_word  (strap_q),
        .clksel_word (clksel_q),
        .programmed  (prog_q),
        .ref_hz      (ref_hz),
        .table_hz    (table_hz),
        .is_off      (is_off),
        .is_bypass   (is_bypass),
        .use_table   (use_table),
        .two_stage   (two_stage),
        .double_a    (double_a),
        .num_a       (num_a),
        .den_a       (den_a),
        .den_b       (den_b),
        .den_bus     (den_bus),
        .bus_shift   (bus_shift)
    );

    always_comb begin
        unique case (state_q)
            ST_RATIO_B: begin div_num = mult_q; div_den = den_b;   end
            ST_BUSDIV:  begin div_num = hpll_q; div_den = den_bus; end
            default:    begin div_num = num_a;  div_den = den_a;   end
        endcase
    end

    pllfreq_div #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go_q),
        .dividend (div_num),
        .divisor  (div_den),
        .ready    (div_ready),
        .quotient (div_quo)
    );

    assign accept = start && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_n = ST_DECODE;
            ST_DECODE:  state_n = (is_off || use_table || is_bypass) ? ST_SCALE : ST_RATIO_A;
            ST_RATIO_A: if (div_ready) state_n = two_stage ? ST_RATIO_B : ST_SCALE;
            ST_RATIO_B: if (div_ready) state_n = ST_SCALE;
            ST_SCALE:   state_n = ST_BUSDIV;
            ST_BUSDIV:  if (div_ready) state_n = ST_FINISH;
            ST_FINISH:  state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    assign is_div_state_n = (state_n == ST_RATIO_A) || (state_n == ST_RATIO_B) ||
                            (state_n == ST_BUSDIV);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q    <= 1'b0;
            pll_q    <= '0;
            strap_q  <= '0;
            clksel_q <= '0;
            prog_q   <= 1'b0;
            mult_q   <= '0;
            hpll_q   <= '0;
            apb_q    <= '0;
            div_go_q <= 1'b0;
        end else begin
            div_go_q <= is_div_state_n && (state_n != state_q);
            if (accept) begin
                fmt_q    <= fmt_new;
                pll_q    <= pll_word;
                strap_q  <= strap_word;
                clksel_q <= clksel_word;
                prog_q   <= prog_flags[PROG_BIT];
            end
            unique case (state_q)
                ST_DECODE: mult_q <= W'(1);
                ST_RATIO_A: if (div_ready) mult_q <= double_a ? {div_quo[W-2:0], 1'b0} : div_quo;
                ST_RATIO_B: if (div_ready) mult_q <= div_quo;
                ST_SCALE: begin
                    if (is_off)         hpll_q <= '0;
                    else if (use_table) hpll_q <= table_hz;
                    else                hpll_q <= ref_hz * mult_q;
                end
                ST_BUSDIV: if (div_ready) apb_q <= div_quo >> bus_shift;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FINISH);
        hpll_hz = hpll_q;
        apb_hz  = apb_q;
    end

endmodule

// File: rtl/pllfreq_calc_chk.sv
module pllfreq_calc_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         fmt_new,
    input logic [W-1:0] pll_word,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] hpll_hz,
    input logic [W-1:0] apb_hz
);

    logic cap_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_off <= 1'b0;
        else if (start && !busy) cap_off <= fmt_new ? pll_word[20] : pll_word[18];
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R9

    AST_START_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(hpll_hz) && $stable(apb_hz))); // R9

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_off) |-> (hpll_hz == '0 && apb_hz == '0)); // R2

    AST_BUS_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (apb_hz <= (hpll_hz >> 1))); // R7

endmodule

bind pllfreq_calc pllfreq_calc_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fmt_new  (fmt_new),
    .pll_word (pll_word),
    .busy     (busy),
    .done     (done),
    .hpll_hz  (hpll_hz),
    .apb_hz   (apb_hz)
);

// File: tb/sim_pllfreq_calc.sv
module sim_pllfreq_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fmt_new = 1'b0;
    logic [31:0] pll_word = '0, strap_word = '0, clksel_word = '0, prog_flags = '0;
    logic        busy, done;
    logic [31:0] hpll_hz, apb_hz;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    typedef struct {
        logic [31:0] hpll;
        logic [31:0] apb;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    pllfreq_calc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_new(fmt_new),
        .pll_word(pll_word), .strap_word(strap_word), .clksel_word(clksel_word),
        .prog_flags(prog_flags), .busy(busy), .done(done),
        .hpll_hz(hpll_hz), .apb_hz(apb_hz)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference model written from the requirements
    function automatic exp_t model(input bit nw, input logic [31:0] pw, sw, cw, fw, input string tag);
        exp_t e;
        int unsigned refc, mult, h;
        refc = sw[23] ? 25_000_000 : (sw[18] ? 48_000_000 : 24_000_000);   // R1
        if (nw) begin
            if (pw[20]) h = 0;                                              // R2
            else begin
                if (pw[19]) mult = 1;                                       // R3
                else mult = ((int'(pw[12:5]) + 1) / (int'(pw[4:0]) + 1)) / (int'(pw[18:13]) + 1); // R4
                h = refc * mult;
            end
        end else begin
            if (pw[18]) h = 0;
            else if (fw[10]) begin
                if (pw[17]) mult = 1;
                else mult = (2 - int'(pw[4])) * ((int'(pw[10:5]) + 2) / (int'(pw[3:0]) + 1)); // R5
                h = refc * mult;
            end else begin                                                  // R6
                case ({sw[23], sw[9:8]})
                    3'b000: h = 384; 3'b001: h = 360; 3'b010: h = 336; 3'b011: h = 408;
                    3'b100: h = 400; 3'b101: h = 375; 3'b110: h = 350; default: h = 425;
                endcase
                h = h * 1_000_000;
            end
        end
        e.hpll = h;
        e.apb  = (h / (int'(cw[25:23]) + 1)) / (nw ? 4 : 2);                // R7
        e.tag  = tag;
        return e;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R9: unexpected done, actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " hpll"}, hpll_hz, e.hpll);
                check({e.tag, " apb"},  apb_hz,  e.apb);
            end
        end
    end

    task automatic run_vec(input bit nw, input logic [31:0] pw, sw, cw, fw, input string tag);
        logic [31:0] h0, a0;
        sb.push_back(model(nw, pw, sw, cw, fw, tag));
        @(posedge clk); #1;
        fmt_new = nw; pll_word = pw; strap_word = sw; clksel_word = cw; prog_flags = fw;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        // R8: disturb inputs right after capture
        fmt_new = ~nw; pll_word = ~pw; strap_word = ~sw; clksel_word = ~cw; prog_flags = ~fw;
        repeat (5) @(posedge clk);
        #1;
        // R10: start while busy must be ignored
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        h0 = hpll_hz; a0 = apb_hz;
        repeat (4) @(negedge clk);
        check({tag, " R9 hold hpll"}, hpll_hz, h0);
        check({tag, " R9 hold apb"},  apb_hz,  a0);
        check({tag, " R9 idle busy"}, {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 busy", {31'd0, busy}, 32'd0);
        check("R11 done", {31'd0, done}, 32'd0);
        check("R11 hpll", hpll_hz, 32'd0);
        check("R11 apb",  apb_hz,  32'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        // newer layout: m=31 n=1 p=0 -> 16 x 24M = 384M, pdiv 1 -> 48M
        run_vec(1'b1, (32'd31 << 5) | 32'd1, 32'h0, 32'd1 << 23, 32'h0, "R4 new 24M");
        // 25M: m=99 n=3 p=1 -> (100/4)/2 = 12 -> 300M
        run_vec(1'b1, (32'd1 << 13) | (32'd99 << 5) | 32'd3, 32'd1 << 23, 32'h0, 32'h0, "R4 new 25M");
        // R1 48M with bypass, pdiv 3
        run_vec(1'b1, 32'd1 << 19, 32'd1 << 18, 32'd3 << 23, 32'h0, "R3 new bypass 48M");
        // R2 off overrides bypass
        run_vec(1'b1, (32'd1 << 20) | (32'd1 << 19) | 32'd7, 32'h0, 32'h0, 32'h0, "R2 new off");
        // R1 both straps: 25M wins; m=10 n=2 -> 3; pdiv 7
        run_vec(1'b1, (32'd10 << 5) | 32'd2, (32'd1 << 23) | (32'd1 << 18), 32'd7 << 23, 32'h0, "R1 priority");
        // R4 32-bit wrap: m=255 n=0 p=0 -> 256 x 25M
        run_vec(1'b1, 32'd255 << 5, 32'd1 << 23, 32'h0, 32'h0, "R4 wrap");
        // older programmed: n=22 od=0 d=1 -> 24 x 24M
        run_vec(1'b0, (32'd22 << 5) | 32'd1, 32'h0, 32'h0, 32'd1 << 10, "R5 old od0");
        // older programmed od=1 n=30 d=3 -> 8 x 25M
        run_vec(1'b0, (32'd30 << 5) | (32'd1 << 4) | 32'd3, 32'd1 << 23, 32'd1 << 23, 32'd1 << 10, "R5 old od1");
        // older bypass at 48M, pdiv 2
        run_vec(1'b0, (32'd1 << 17) | (32'd5 << 5), 32'd1 << 18, 32'd2 << 23, 32'd1 << 10, "R3 old bypass");
        // older off
        run_vec(1'b0, (32'd1 << 18) | (32'd5 << 5), 32'h0, 32'h0, 32'd1 << 10, "R2 old off");
        // older table 24M sel 3 -> 408M
        run_vec(1'b0, 32'h0, 32'd3 << 8, 32'h0, 32'h0, "R6 table 24M");
        // older table 25M sel 1 -> 375M, pdiv 4
        run_vec(1'b0, 32'h0, (32'd1 << 23) | (32'd1 << 8), 32'd4 << 23, 32'h0, "R6 table 25M");
        // older table 48M sel 2 -> 336M; bypass bit has no effect unprogrammed
        run_vec(1'b0, 32'd1 << 17, (32'd1 << 18) | (32'd2 << 8), 32'h0, 32'h0, "R6 table bypass ignored");
        // older table with off bit -> 0
        run_vec(1'b0, 32'd1 << 18, 32'd2 << 8, 32'h0, 32'h0, "R2 table off");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL R9: watchdog expired, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule